// File: doc/BRIEF.md
# Base and Limit Address Guard

This block sits on the path from a processor to memory. Each access request carries an address and a mode flag that says whether the requester runs in kernel or user mode. User requests are checked against a window held in two privileged registers: a base and a limit. In the default relocating build, a user address is also shifted by adding the base. Requests inside the window go on to memory. Requests outside it are dropped and a bounds trap is raised. Kernel requests skip the check and pass through unchanged.

The two registers are loaded through a small write port. Each write carries the requester's own mode flag. A write from kernel mode updates the selected register at the next clock edge. A write from user mode leaves both registers as they were and raises a privilege trap.

All outputs are registered, so every result appears one clock after its stimulus. The parameter `RELOCATE` selects the build. With `RELOCATE` set to 1, the unit adds the base to user addresses and checks the offset against the limit. With `RELOCATE` set to 0, the unit compares the raw address against the base and the limit and does not translate it.

Top module: `bl_guard`

## Requirements
- R1: After synchronous reset, both registers hold zero and `out_valid`, `trap` and `trap_cause` are 0. With a limit of zero, any user request therefore traps with cause 2'b01.
- R2: A write with `cfg_we`=1 and `cfg_kernel`=1 loads `cfg_data` at the next clock edge. `cfg_sel`=0 selects the base register and `cfg_sel`=1 selects the limit register.
- R3: A write with `cfg_we`=1 and `cfg_kernel`=0 changes neither register. One cycle later it raises `trap`=1 with `trap_cause`=2'b10.
- R4: With `RELOCATE`=1, a legal user request is forwarded with `out_addr` equal to the request address plus the base.
- R5: A user request is legal only when its address is at or above the base and below base plus limit, so the last legal address is base+limit−1. With `RELOCATE`=1 this address is the relocated one, so the logical address must be below the limit. With `RELOCATE`=0 the raw address is compared.
- R6: An illegal user request gives `trap`=1 and `trap_cause`=2'b01 one cycle later. In that cycle `out_valid` is 0 and `out_addr` is 0.
- R7: The base plus limit sum and the relocation sum are formed one bit wider than the address. A window or a translation that runs past the top of the address space therefore never wraps to low addresses. A relocated address that does not fit in AW bits is treated as illegal.
- R8: A kernel request (`req_kernel`=1) is never bounds-checked. It is forwarded with `out_addr` equal to the request address.
- R9: Results are due exactly one cycle after the request. In a cycle with no request and no write, the next cycle shows `out_valid`=0 and `trap`=0.
- R10: When a user-mode write and a request arrive in the same cycle, the cause is 2'b10 and `out_valid` is 0 in the next cycle.
- R11: A request in the same cycle as a kernel write is checked against the register values from before that write.
- R12: `trap_cause` is 2'b00 exactly when `trap` is 0, and it never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 = base, 1 = limit |
| cfg_kernel | input | 1 | Mode of the writer: 1 = kernel |
| cfg_data | input | AW | Value to write |
| req_valid | input | 1 | Access request strobe |
| req_kernel | input | 1 | Mode of the requester: 1 = kernel |
| req_addr | input | AW | Address of the request |
| out_valid | output | 1 | Forwarded access to memory, one cycle later |
| out_addr | output | AW | Physical address, zero when nothing is forwarded |
| trap | output | 1 | Trap raised, one cycle later |
| trap_cause | output | 2 | 00 none, 01 bounds, 10 user-mode register write |

## Verification
Every result of this unit, whether a forwarded address, a bounds trap or a privilege trap, is due in the cycle right after its stimulus. A register write affects only requests made from the next cycle on. The bench applies each stimulus on a falling edge and reads the outputs on the following falling edge, which is half a cycle after the one capturing edge. It then releases the inputs, so the cycle after that can be checked as idle. The same-cycle write case is checked by sending a request together with a kernel write and comparing against the old limit, and then repeating the request one cycle later.

// File: rtl/bl_pkg.sv
package bl_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_BOUNDS = 2'b01,
        CAUSE_PRIV   = 2'b10
    } cause_e;

    typedef struct packed {
        logic   pass;
        logic   trap;
        cause_e cause;
    } verdict_t;

    localparam logic SEL_BASE  = 1'b0;
    localparam logic SEL_LIMIT = 1'b1;

    function automatic verdict_t judge(input logic valid, input logic priv_fault,
                                       input logic bounds_fault);
        verdict_t v;
        v.trap  = priv_fault | bounds_fault;
        v.pass  = valid & ~v.trap;
        if (priv_fault)
            v.cause = CAUSE_PRIV;
        else if (bounds_fault)
            v.cause = CAUSE_BOUNDS;
        else
            v.cause = CAUSE_NONE;
        return v;
    endfunction

endpackage

// File: rtl/bl_regs.sv
module bl_regs #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic          cfg_kernel,
    input  logic [AW-1:0] cfg_data,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] limit_q,
    output logic          priv_fault
);
    import bl_pkg::*;

    logic wr_ok;

    always_comb begin
        wr_ok      = cfg_we & cfg_kernel;
        priv_fault = cfg_we & ~cfg_kernel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (wr_ok) begin
            if (cfg_sel == SEL_BASE)
                base_q <= cfg_data;
            else
                limit_q <= cfg_data;
        end
    end

endmodule

// File: rtl/bl_xlate.sv
module bl_xlate #(
    parameter int AW       = 32,
    parameter bit RELOCATE = 1'b1
) (
    input  logic          req_kernel,
    input  logic [AW-1:0] req_addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic [AW-1:0] phys,
    output logic          in_range
);
    localparam int WW = AW + 1;

    logic [WW-1:0] win_end;
    logic [WW-1:0] cand;
    logic [WW-1:0] base_w;
    logic          fits;

    always_comb begin
        base_w  = {1'b0, base};
        win_end = base_w + {1'b0, limit};
    end

    generate
        if (RELOCATE) begin : g_reloc
            always_comb begin
                cand = {1'b0, req_addr} + base_w;
                fits = ~cand[AW];
            end
        end else begin : g_flat
            always_comb begin
                cand = {1'b0, req_addr};
                fits = 1'b1;
            end
        end
    endgenerate

    always_comb begin
        in_range = fits && (cand >= base_w) && (cand < win_end);
        phys     = req_kernel ? req_addr : cand[AW-1:0];
    end

endmodule

// File: rtl/bl_outreg.sv
module bl_outreg #(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  bl_pkg::verdict_t verdict,
    input  logic [AW-1:0]    phys,
    output logic             out_valid,
    output logic [AW-1:0]    out_addr,
    output logic             trap,
    output logic [1:0]       trap_cause
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_addr   <= '0;
            trap       <= 1'b0;
            trap_cause <= 2'b00;
        end else begin
            out_valid  <= verdict.pass;
            out_addr   <= verdict.pass ? phys : '0;
            trap       <= verdict.trap;
            trap_cause <= verdict.cause;
        end
    end

endmodule

// File: rtl/bl_guard.sv
module bl_guard #(
    parameter int AW       = 32,
    parameter bit RELOCATE = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic          cfg_kernel,
    input  logic [AW-1:0] cfg_data,
    input  logic          req_valid,
    input  logic          req_kernel,
    input  logic [AW-1:0] req_addr,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic          trap,
    output logic [1:0]    trap_cause
);
    import bl_pkg::*;

    logic [AW-1:0] base_q;
    logic [AW-1:0] limit_q;
    logic          priv_fault;
    logic [AW-1:0] phys;
    logic          in_range;
    logic          bounds_fault;
    verdict_t      verdict;

    bl_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_kernel (cfg_kernel),
        .cfg_data   (cfg_data),
        .base_q     (base_q),
        .limit_q    (limit_q),
        .priv_fault (priv_fault)
    );

    bl_xlate #(.AW(AW), .RELOCATE(RELOCATE)) u_xlate (
        .req_kernel (req_kernel),
        .req_addr   (req_addr),
        .base       (base_q),
        .limit      (limit_q),
        .phys       (phys),
        .in_range   (in_range)
    );

    always_comb begin
        bounds_fault = req_valid & ~req_kernel & ~in_range;
        verdict      = judge(req_valid, priv_fault, bounds_fault);
    end

    bl_outreg #(.AW(AW)) u_out (
        .clk        (clk),
        .rst        (rst),
        .verdict    (verdict),
        .phys       (phys),
        .out_valid  (out_valid),
        .out_addr   (out_addr),
        .trap       (trap),
        .trap_cause (trap_cause)
    );

endmodule

// File: rtl/bl_guard_chk.sv
module bl_guard_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic          cfg_kernel,
    input logic          req_valid,
    input logic          req_kernel,
    input logic [AW-1:0] req_addr,
    input logic          out_valid,
    input logic [AW-1:0] out_addr,
    input logic          trap,
    input logic [1:0]    trap_cause
);
    // R3: a user-mode write raises the privilege trap one cycle later
    a_r3_priv_trap: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_kernel) |=> (trap && trap_cause == 2'b10 && !out_valid));

    // R8: kernel requests are forwarded unchanged
    a_r8_kernel_pass: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kernel && !(cfg_we && !cfg_kernel))
            |=> (out_valid && out_addr == $past(req_addr)));

    // R9: nothing appears without a stimulus one cycle earlier
    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !cfg_we) |=> (!out_valid && !trap));

    // R6: a trapped cycle never reaches memory
    a_r6_blocked: assert property (@(posedge clk) disable iff (rst)
        trap |-> (!out_valid && out_addr == '0));

    // R12: cause code consistent with the trap flag
    a_r12_cause_code: assert property (@(posedge clk) disable iff (rst)
        (trap_cause != 2'b11) && (trap == (trap_cause != 2'b00)));

endmodule

bind bl_guard bl_guard_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_kernel (cfg_kernel),
    .req_valid  (req_valid),
    .req_kernel (req_kernel),
    .req_addr   (req_addr),
    .out_valid  (out_valid),
    .out_addr   (out_addr),
    .trap       (trap),
    .trap_cause (trap_cause)
);

// File: tb/sim_bl_guard.sv
`timescale 1ns/100ps
module sim_bl_guard;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we, cfg_sel, cfg_kernel;
    logic [AW-1:0] cfg_data;
    logic          req_valid, req_kernel;
    logic [AW-1:0] req_addr;
    logic          v0, t0, v1, t1;
    logic [AW-1:0] a0, a1;
    logic [1:0]    c0, c1;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bl_guard #(.AW(AW), .RELOCATE(1'b1)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_kernel(cfg_kernel), .cfg_data(cfg_data), .req_valid(req_valid),
        .req_kernel(req_kernel), .req_addr(req_addr), .out_valid(v0),
        .out_addr(a0), .trap(t0), .trap_cause(c0));

    bl_guard #(.AW(AW), .RELOCATE(1'b0)) u1 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_kernel(cfg_kernel), .cfg_data(cfg_data), .req_valid(req_valid),
        .req_kernel(req_kernel), .req_addr(req_addr), .out_valid(v1),
        .out_addr(a1), .trap(t1), .trap_cause(c1));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus at a falling edge, return at the next falling edge
    task automatic step(input logic we, input logic sel, input logic ck,
                        input logic [AW-1:0] data, input logic rv, input logic rk,
                        input logic [AW-1:0] addr);
        cfg_we = we; cfg_sel = sel; cfg_kernel = ck; cfg_data = data;
        req_valid = rv; req_kernel = rk; req_addr = addr;
        @(negedge clk);
        cfg_we = 0; cfg_sel = 0; cfg_kernel = 0; cfg_data = '0;
        req_valid = 0; req_kernel = 0; req_addr = '0;
    endtask

    task automatic kwrite(input logic sel, input logic [AW-1:0] d);
        step(1, sel, 1, d, 0, 0, '0);
    endtask

    task automatic ureq(input logic [AW-1:0] addr);
        step(0, 0, 0, '0, 1, 0, addr);
    endtask

    task automatic t_reset;
        rst = 1;
        step(0, 0, 0, '0, 0, 0, '0);
        step(0, 0, 0, '0, 0, 0, '0);
        rst = 0;
        chk("R1 reset out_valid", v0, 0);
        chk("R1 reset trap", t0, 0);
        chk("R1 reset cause", c0, 0);
        ureq(32'd0);
        chk("R1 zero limit trap", t0, 1);
        chk("R1 zero limit cause", c0, 2'b01);
    endtask

    task automatic t_load_reloc;
        kwrite(0, 32'd14000);
        kwrite(1, 32'd1000);
        ureq(32'd346);
        chk("R2 R4 reloc valid", v0, 1);
        chk("R4 reloc addr", a0, 32'd14346);
        chk("R12 no cause", c0, 2'b00);
        ureq(32'd999);
        chk("R5 last legal valid", v0, 1);
        chk("R5 last legal addr", a0, 32'd14999);
        ureq(32'd1000);
        chk("R6 over limit trap", t0, 1);
        chk("R6 over limit cause", c0, 2'b01);
        chk("R6 over limit valid", v0, 0);
        chk("R6 over limit addr", a0, 0);
    endtask

    task automatic t_flat;
        kwrite(0, 32'd300040);
        kwrite(1, 32'd120900);
        ureq(32'd300040);
        chk("R5 flat base valid", v1, 1);
        chk("R5 flat base addr", a1, 32'd300040);
        ureq(32'd420939);
        chk("R5 flat top valid", v1, 1);
        chk("R5 flat top addr", a1, 32'd420939);
        ureq(32'd420940);
        chk("R6 flat above cause", c1, 2'b01);
        chk("R6 flat above valid", v1, 0);
        ureq(32'd300039);
        chk("R6 flat below cause", c1, 2'b01);
    endtask

    task automatic t_user_write;
        kwrite(0, 32'd14000);
        kwrite(1, 32'd1000);
        step(1, 0, 0, 32'd5, 0, 0, '0);
        chk("R3 priv trap", t0, 1);
        chk("R3 priv cause", c0, 2'b10);
        chk("R3 priv valid", v0, 0);
        step(1, 1, 0, 32'd9, 0, 0, '0);
        chk("R3 priv cause limit", c1, 2'b10);
        ureq(32'd346);
        chk("R3 base kept addr", a0, 32'd14346);
        ureq(32'd999);
        chk("R3 limit kept valid", v0, 1);
    endtask

    task automatic t_kernel_pass;
        step(0, 0, 0, '0, 1, 1, 32'd50);
        chk("R8 kernel valid", v0, 1);
        chk("R8 kernel addr", a0, 32'd50);
        chk("R8 kernel no trap", t0, 0);
        chk("R8 flat kernel addr", a1, 32'd50);
    endtask

    task automatic t_idle;
        ureq(32'd10);
        chk("R9 one cycle valid", v0, 1);
        @(negedge clk);
        chk("R9 idle valid", v0, 0);
        chk("R9 idle trap", t0, 0);
    endtask

    task automatic t_priority;
        step(1, 0, 0, 32'd1, 1, 0, 32'd5000);
        chk("R10 priority cause", c0, 2'b10);
        chk("R10 priority valid", v0, 0);
        step(1, 0, 0, 32'd1, 1, 0, 32'd10);
        chk("R10 legal req dropped", v0, 0);
    endtask

    task automatic t_same_cycle;
        step(1, 1, 1, 32'd2000, 1, 0, 32'd1500);
        chk("R11 old limit cause", c0, 2'b01);
        ureq(32'd1500);
        chk("R11 new limit valid", v0, 1);
        chk("R11 new limit addr", a0, 32'd15500);
    endtask

    task automatic t_overflow;
        kwrite(0, 32'hFFFF_FF00);
        kwrite(1, 32'h0000_0200);
        ureq(32'h0000_00FF);
        chk("R7 fits valid", v0, 1);
        chk("R7 fits addr", a0, 32'hFFFF_FFFF);
        ureq(32'h0000_0100);
        chk("R7 wrap cause", c0, 2'b01);
        ureq(32'hFFFF_FFFF);
        chk("R7 flat top valid", v1, 1);
        ureq(32'h0000_0050);
        chk("R7 flat low cause", c1, 2'b01);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1;
        cfg_we = 0; cfg_sel = 0; cfg_kernel = 0; cfg_data = '0;
        req_valid = 0; req_kernel = 0; req_addr = '0;
        @(negedge clk);
        t_reset();
        t_load_reloc();
        t_user_write();
        t_kernel_pass();
        t_idle();
        t_priority();
        t_same_cycle();
        t_flat();
        t_overflow();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule